// File: doc/BRIEF.md
# BCD Real-Time Calendar with Two-Stage Prescaler

This block keeps wall-clock time and calendar date in packed BCD. A pair of cascaded counters, a coarse stage followed by a fine stage, divides the input clock down to a once-per-second advance of the calendar. The calendar runs in 24-hour format only. It handles seconds, minutes and hours, and it handles days of the month with correct month lengths and leap years. It also advances the weekday and carries from month into a two-digit year.

Software reaches the block through a small word-addressed register port with four words: time, date, prescaler limits, and a combined status/control word. Time and date reads return a shadow copy. That copy is refreshed after each calendar advance and when the block leaves programming mode. A sync flag tells software when the copy is fresh. To change the time, the date or the prescaler, software raises a programming request. This halts the calendar and clears the divider. Software then waits for the acknowledge flag, which rises two cycles later, and only after that are the writes accepted. Dropping the request resumes counting from a cleared divider. The shadow copy is then refreshed, and the sync flag re-asserts.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time word reads 0x000000, the date word reads 0x002101 (year 00, weekday 1, month 01, day 01), the prescaler word reads 0x007F7FFF (both limits at maximum) and the status word reads 0.
- R2: Time word: seconds BCD in bits 6:0, minutes in bits 14:8, hours in bits 21:16. Each advance adds one second, with carries at 59 s and 59 min, and 23:59:59 wraps to 00:00:00.
- R3: Date word: day BCD in bits 5:0, month in bits 12:8, weekday in bits 15:13 (1 is Monday through 7 is Sunday), year in bits 23:16. When the day rolls over, the weekday advances, and 7 wraps to 1.
- R4: The last day of a month is 31, except 30 for months 04, 06, 09 and 11, and for month 02 it is 28, or 29 when the BCD year is a multiple of four. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R5: Prescaler word: fine limit S in bits 14:0, coarse limit A in bits 22:16. After programming mode is left with a write at clock edge E, the calendar advances at edges E+k*(A+1)*(S+1).
- R6: While the request bit is set, the calendar does not advance and the divider is held cleared.
- R7: Status bit 7 is the programming request (read/write). Status bit 6 is the acknowledge. It reads 1 from the second edge after the edge that sets the request, and reads 0 from the edge after the request is cleared.
- R8: Writes to the time, date and prescaler words take effect only while the acknowledge is 1. Otherwise they are ignored.
- R9: Time and date reads return the shadow copy. Writing status with bit 5 at 0 clears the sync flag (bit 5), and writing 1 there leaves it unchanged. After an exit write at edge E, the shadow is refreshed at E+2 and the flag sets at E+4. After an advance at edge T, the shadow is refreshed at T+1 and the flag sets at T+3.
- R10: Status bit 4 reads 1 exactly when the running year is nonzero.
- R11: Status bit 16, the hour-format bit, always reads 0 (24-hour), and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Calendar input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word select: 0 time, 1 date, 2 prescaler, 3 status/control |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for the selected word (combinational) |

## Verification
The hardest states to reach are the calendar boundaries: a leap-year February 29, a 30-day month end, and the 99-to-00 year wrap with December 31. With the reset divider, reaching any of them from reset would take years of simulated cycles. The stimulus enters programming mode, shrinks the prescaler to a six-cycle period and loads the calendar one second before each boundary. It then leaves programming mode and samples the shadow words at the exact edges where the first advance becomes visible. A second difficult point is the relative timing of the exit write, the shadow refresh and the sync flag. The bench checks these on specific negedges counted from the exit write.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
// Shared types, register addresses, status bit positions and BCD helpers
// for the real-time calendar. Assumes all calendar fields hold valid BCD.
package cal_pkg;

    localparam logic [1:0] ADDR_TIME  = 2'd0;
    localparam logic [1:0] ADDR_DATE  = 2'd1;
    localparam logic [1:0] ADDR_PRESC = 2'd2;
    localparam logic [1:0] ADDR_STAT  = 2'd3;

    localparam int BIT_REQ   = 7;
    localparam int BIT_ACK   = 6;
    localparam int BIT_SYNC  = 5;
    localparam int BIT_INITD = 4;
    localparam int BIT_FMT   = 16;

    typedef struct packed {
        logic [5:0] hr;
        logic [6:0] mn;
        logic [6:0] sc;
    } cal_time_t;

    typedef struct packed {
        logic [7:0] yr;
        logic [2:0] wd;
        logic [4:0] mo;
        logic [5:0] dy;
    } cal_date_t;

    localparam cal_time_t TIME_RST = '{hr: 6'h00, mn: 7'h00, sc: 7'h00};
    localparam cal_date_t DATE_RST = '{yr: 8'h00, wd: 3'd1, mo: 5'h01, dy: 6'h01};

    // Add one to a two-digit BCD value (no wrap past 99 handled here).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // Leap test on BCD digits: value divisible by 4.
    function automatic logic yr_leap(input logic [7:0] y);
        if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
        return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    endfunction

    // Last day of the month in BCD.
    function automatic logic [5:0] month_last(input logic [4:0] mo, input logic [7:0] y);
        case (mo)
            5'h02:                      return yr_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
// Two-stage divider: a coarse counter wraps at a_lim and each wrap steps a
// fine counter that wraps at s_lim; tick marks the cycle of the joint wrap.
// Assumes limits change only while run is low (both counters then cleared).
module cal_prescaler #(
    parameter int AW = 7,
    parameter int SW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [AW-1:0] a_lim,
    input  logic [SW-1:0] s_lim,
    output logic          tick
);
    logic [AW-1:0] a_cnt;
    logic [SW-1:0] s_cnt;
    logic          a_end;

    assign a_end = (a_cnt == a_lim);
    assign tick  = run && a_end && (s_cnt == s_lim);

    // Divider counters, held at zero while halted.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            a_cnt <= '0;
            s_cnt <= '0;
        end else if (a_end) begin
            a_cnt <= '0;
            s_cnt <= (s_cnt == s_lim) ? '0 : s_cnt + 1'b1;
        end else begin
            a_cnt <= a_cnt + 1'b1;
        end
    end

    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_cnt <= a_lim) && (s_cnt <= s_lim));

    p_halt_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (a_cnt == '0) && (s_cnt == '0));

endmodule

// File: rtl/cal_datetime.sv
`timescale 1ns/1ps
// Live BCD time and date registers with the one-second advance logic:
// 24-hour wrap, month lengths, leap years, weekday and year rollover.
// Assumes writes and ticks never coincide (writes only while halted).
module cal_datetime
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      wr_time,
    input  logic      wr_date,
    input  cal_time_t tm_in,
    input  cal_date_t dt_in,
    output cal_time_t tm_q,
    output cal_date_t dt_q
);
    cal_time_t tm_n;
    cal_date_t dt_n;
    logic [7:0] sc_i, mn_i, hr_i, dy_i, mo_i, yr_i;
    logic sc_wrap, mn_wrap, hr_wrap, dy_wrap, mo_wrap;

    assign sc_i = bcd_inc({1'b0, tm_q.sc});
    assign mn_i = bcd_inc({1'b0, tm_q.mn});
    assign hr_i = bcd_inc({2'b0, tm_q.hr});
    assign dy_i = bcd_inc({2'b0, dt_q.dy});
    assign mo_i = bcd_inc({3'b0, dt_q.mo});
    assign yr_i = bcd_inc(dt_q.yr);

    // Carry chain from seconds up to year.
    always_comb begin
        sc_wrap = (tm_q.sc == 7'h59);
        mn_wrap = sc_wrap && (tm_q.mn == 7'h59);
        hr_wrap = mn_wrap && (tm_q.hr == 6'h23);
        dy_wrap = hr_wrap && (dt_q.dy == month_last(dt_q.mo, dt_q.yr));
        mo_wrap = dy_wrap && (dt_q.mo == 5'h12);
    end

    // Next time and date after one second.
    always_comb begin
        tm_n    = tm_q;
        dt_n    = dt_q;
        tm_n.sc = sc_wrap ? 7'h00 : sc_i[6:0];
        if (sc_wrap) tm_n.mn = (tm_q.mn == 7'h59) ? 7'h00 : mn_i[6:0];
        if (mn_wrap) tm_n.hr = (tm_q.hr == 6'h23) ? 6'h00 : hr_i[5:0];
        if (hr_wrap) begin
            dt_n.dy = dy_wrap ? 6'h01 : dy_i[5:0];
            dt_n.wd = (dt_q.wd == 3'd7) ? 3'd1 : 3'(dt_q.wd + 3'd1);
        end
        if (dy_wrap) dt_n.mo = mo_wrap ? 5'h01 : mo_i[4:0];
        if (mo_wrap) dt_n.yr = (dt_q.yr == 8'h99) ? 8'h00 : yr_i;
    end

    // Time register: write while programming, otherwise advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       tm_q <= TIME_RST;
        else if (wr_time) tm_q <= tm_in;
        else if (tick)    tm_q <= tm_n;
    end

    // Date register: write while programming, otherwise advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       dt_q <= DATE_RST;
        else if (wr_date) dt_q <= dt_in;
        else if (tick)    dt_q <= dt_n;
    end

    p_time_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_time) |=> $stable(tm_q));

    p_date_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_date) |=> $stable(dt_q));

    p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_time && tm_q.sc == 7'h59) |=> (tm_q.sc == 7'h00));

    p_wday_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_date && hr_wrap && dt_q.wd == 3'd7) |=> (dt_q.wd == 3'd1));

endmodule

// File: rtl/cal_init_ctrl.sv
`timescale 1ns/1ps
// Programming-mode handshake and shadow copy: the request halts the
// calendar, the acknowledge follows after INIT_LAT edges, and the shadow
// time/date refresh one cycle after each advance or mode exit, with the
// sync flag following two cycles after that. Assumes INIT_LAT >= 1.
module cal_init_ctrl
    import cal_pkg::*;
#(
    parameter int INIT_LAT = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_wr,
    input  logic      req_val,
    input  logic      sync_clr,
    input  logic      tick,
    input  cal_time_t tm_live,
    input  cal_date_t dt_live,
    output logic      req,
    output logic      ack,
    output logic      sync,
    output cal_time_t tm_sh,
    output cal_date_t dt_sh
);
    logic [INIT_LAT-1:0] pipe;
    logic exit_ev, ref_q, ref_d1, ref_d2;

    // Request bit written through the status word.
    always_ff @(posedge clk) begin
        if (!rst_n)      req <= 1'b0;
        else if (req_wr) req <= req_val;
    end

    // First stage of the acknowledge delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= 1'b0;
        else        pipe[0] <= req;
    end

    for (genvar i = 1; i < INIT_LAT; i++) begin : g_ack_dly
        // Later stages drop at once when the request is withdrawn.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[i] <= 1'b0;
            else        pipe[i] <= pipe[i-1] & req;
        end
    end

    assign ack     = pipe[INIT_LAT-1];
    assign exit_ev = ack & ~req;

    // Refresh pipeline: event, shadow load, then two stages to the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= 1'b0;
            ref_d1 <= 1'b0;
            ref_d2 <= 1'b0;
        end else begin
            ref_q  <= tick | exit_ev;
            ref_d1 <= ref_q;
            ref_d2 <= ref_d1;
        end
    end

    // Shadow copy of the live calendar.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_sh <= TIME_RST;
            dt_sh <= DATE_RST;
        end else if (ref_q) begin
            tm_sh <= tm_live;
            dt_sh <= dt_live;
        end
    end

    // Sync flag: hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        sync <= 1'b0;
        else if (ref_d2)   sync <= 1'b1;
        else if (sync_clr) sync <= 1'b0;
    end

    p_ack_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req));

    p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ack);

    p_sync_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_clr && !ref_d2) |=> !sync);

    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_q |=> $stable(tm_sh) && $stable(dt_sh));

endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
// Top of the real-time calendar: register decode, prescaler limit storage
// and read-back mux. Calendar and prescaler writes are gated by the
// programming acknowledge; reads of time and date come from the shadow.
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int AW       = 7,
    parameter int SW       = 15,
    parameter int INIT_LAT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    localparam int A_LO = 16;
    localparam int A_HI = A_LO + AW - 1;

    logic [AW-1:0] a_lim;
    logic [SW-1:0] s_lim;
    logic req, ack, sync, tick, initd;
    logic wr_stat, wr_time, wr_date, wr_presc;
    cal_time_t tm_live, tm_sh, tm_in;
    cal_date_t dt_live, dt_sh, dt_in;
    logic unused_hi;

    assign unused_hi = ^wdata[31:24];

    assign wr_stat  = wr_en && (addr == ADDR_STAT);
    assign wr_time  = wr_en && ack && (addr == ADDR_TIME);
    assign wr_date  = wr_en && ack && (addr == ADDR_DATE);
    assign wr_presc = wr_en && ack && (addr == ADDR_PRESC);

    assign tm_in = '{hr: wdata[21:16], mn: wdata[14:8], sc: wdata[6:0]};
    assign dt_in = '{yr: wdata[23:16], wd: wdata[15:13], mo: wdata[12:8], dy: wdata[5:0]};
    assign initd = (dt_live.yr != 8'h00);

    // Prescaler limits, writable only while acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_lim <= '1;
            s_lim <= '1;
        end else if (wr_presc) begin
            a_lim <= wdata[A_HI:A_LO];
            s_lim <= wdata[SW-1:0];
        end
    end

    cal_prescaler #(.AW(AW), .SW(SW)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!req),
        .a_lim (a_lim),
        .s_lim (s_lim),
        .tick  (tick)
    );

    cal_datetime u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_time (wr_time),
        .wr_date (wr_date),
        .tm_in   (tm_in),
        .dt_in   (dt_in),
        .tm_q    (tm_live),
        .dt_q    (dt_live)
    );

    cal_init_ctrl #(.INIT_LAT(INIT_LAT)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_wr   (wr_stat),
        .req_val  (wdata[BIT_REQ]),
        .sync_clr (wr_stat && !wdata[BIT_SYNC]),
        .tick     (tick),
        .tm_live  (tm_live),
        .dt_live  (dt_live),
        .req      (req),
        .ack      (ack),
        .sync     (sync),
        .tm_sh    (tm_sh),
        .dt_sh    (dt_sh)
    );

    // Read-back mux for the selected word.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_TIME: begin
                rdata[6:0]   = tm_sh.sc;
                rdata[14:8]  = tm_sh.mn;
                rdata[21:16] = tm_sh.hr;
            end
            ADDR_DATE: begin
                rdata[5:0]   = dt_sh.dy;
                rdata[12:8]  = dt_sh.mo;
                rdata[15:13] = dt_sh.wd;
                rdata[23:16] = dt_sh.yr;
            end
            ADDR_PRESC: begin
                rdata[SW-1:0]    = s_lim;
                rdata[A_HI:A_LO] = a_lim;
            end
            default: begin
                rdata[BIT_REQ]   = req;
                rdata[BIT_ACK]   = ack;
                rdata[BIT_SYNC]  = sync;
                rdata[BIT_INITD] = initd;
                rdata[BIT_FMT]   = 1'b0;
            end
        endcase
    end

    p_presc_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> $stable(a_lim) && $stable(s_lim));

    p_no_tick_in_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !tick);

endmodule

// File: tb/bcd_calendar_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    int checks = 0;
    int errors = 0;

    bcd_calendar dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #0.5 d = rdata;
    endtask

    task automatic enter_init();
        logic [31:0] v;
        wr(2'd3, 32'h80);
        repeat (3) @(negedge clk);
        rd(2'd3, v);
        chk("R7 ack high two edges after request", 32'(v[6]), 32'd1);
    endtask

    // Exit write at edge E; returns at the negedge after E+4.
    task automatic leave_init();
        logic [31:0] v;
        wr(2'd3, 32'h0);
        repeat (2) @(negedge clk);
        rd(2'd3, v);
        chk("R7 ack low one edge after request cleared", 32'(v[6]), 32'd0);
        repeat (2) @(negedge clk);
        rd(2'd3, v);
        chk("R9 sync still low at E+3", 32'(v[5]), 32'd0);
        @(negedge clk);
        rd(2'd3, v);
        chk("R9 sync set at E+4", 32'(v[5]), 32'd1);
    endtask

    task automatic prog(input logic [31:0] p, input logic [31:0] t, input logic [31:0] d);
        enter_init();
        wr(2'd2, p);
        wr(2'd0, t);
        wr(2'd1, d);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk("R1 reset time", v, 32'h000000);
        rd(2'd1, v); chk("R1 reset date", v, 32'h002101);
        rd(2'd2, v); chk("R1 reset prescaler", v, 32'h007F7FFF);
        rd(2'd3, v); chk("R1 R10 reset status", v, 32'h0);
    endtask

    task automatic t_locked();
        logic [31:0] v;
        wr(2'd2, 32'h00010002);
        wr(2'd0, 32'h123456);
        wr(2'd1, 32'h991111);
        @(negedge clk);
        rd(2'd2, v); chk("R8 prescaler write ignored when idle", v, 32'h007F7FFF);
        wr(2'd3, 32'h80);
        wr(2'd2, 32'h00010002);
        @(negedge clk);
        rd(2'd3, v); chk("R7 ack low one edge after request", 32'(v[6]), 32'd0);
        @(negedge clk);
        rd(2'd3, v); chk("R7 ack high at second edge", 32'(v[6]), 32'd1);
        rd(2'd2, v); chk("R8 prescaler write ignored before ack", v, 32'h007F7FFF);
        leave_init();
        rd(2'd0, v); chk("R8 time write ignored when idle", v, 32'h000000);
        rd(2'd1, v); chk("R8 date write ignored when idle", v, 32'h002101);
        wr(2'd3, 32'h00010020);
        @(negedge clk);
        rd(2'd3, v); chk("R11 R9 format bit stays 0, sync kept", v, 32'h20);
        wr(2'd3, 32'h0);
        @(negedge clk);
        rd(2'd3, v); chk("R9 sync cleared by software", v, 32'h0);
    endtask

    task automatic t_leap_ticks();
        logic [31:0] v;
        prog(32'h00010002, 32'h235958, 32'h246228);
        @(negedge clk);
        rd(2'd0, v); chk("R9 read in init shows old shadow", v, 32'h000000);
        rd(2'd2, v); chk("R5 R8 prescaler written under ack", v, 32'h00010002);
        leave_init();
        rd(2'd0, v); chk("R2 programmed time visible after exit", v, 32'h235958);
        rd(2'd1, v); chk("R3 programmed date visible after exit", v, 32'h246228);
        repeat (2) @(negedge clk);
        rd(2'd0, v); chk("R5 no advance visible at E+6", v, 32'h235958);
        @(negedge clk);
        rd(2'd0, v); chk("R5 R9 first advance visible at E+7", v, 32'h235959);
        repeat (6) @(negedge clk);
        rd(2'd0, v); chk("R2 midnight wrap", v, 32'h000000);
        rd(2'd1, v); chk("R4 leap year Feb 28 to 29", v, 32'h248229);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        prog(32'h00030003, 32'h101010, 32'h212101);
        leave_init();
        wr(2'd3, 32'h80);
        repeat (40) @(negedge clk);
        leave_init();
        rd(2'd0, v); chk("R6 calendar halted during request", v, 32'h101010);
    endtask

    task automatic t_roll(input string tag, input logic [31:0] tin, input logic [31:0] din,
                          input logic [31:0] tout, input logic [31:0] dout);
        logic [31:0] v;
        prog(32'h00010002, tin, din);
        leave_init();
        repeat (3) @(negedge clk);
        rd(2'd0, v); chk({tag, " time"}, v, tout);
        rd(2'd1, v); chk({tag, " date"}, v, dout);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (R1..R11 run) actual %0d cycles expected fewer", 200000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_leap_ticks();
        t_stop();
        t_roll("R4 R3 non-leap Feb, Sunday to Monday", 32'h235959, 32'h23E228, 32'h000000, 32'h232301);
        t_roll("R4 leap Feb 29 to Mar 01", 32'h235959, 32'h248229, 32'h000000, 32'h24A301);
        t_roll("R4 30-day month end", 32'h235959, 32'h232430, 32'h000000, 32'h234501);
        t_roll("R2 BCD digit carry", 32'h123409, 32'h206131, 32'h123410, 32'h206131);
        prog(32'h00010002, 32'h235959, 32'h99B231);
        leave_init();
        rd(2'd3, v); chk("R10 initialized flag with year 99", 32'(v[4]), 32'd1);
        repeat (3) @(negedge clk);
        rd(2'd0, v); chk("R2 year-end time wrap", v, 32'h000000);
        rd(2'd1, v); chk("R4 year 99 Dec 31 to 00 Jan 01", v, 32'h00C101);
        rd(2'd3, v); chk("R10 initialized flag drops with year 00", 32'(v[4]), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule